// File: doc/BRIEF.md
# Reset Request Combiner with Cause Register

This block merges the reset requests of a small microcontroller into a single internal reset. Its inputs are a power-on request, an asynchronous active-low reset pin, a watchdog timeout, a low-voltage detect, an illegal-opcode flag and an illegal-address flag. All of them drive the same internal reset. The reset is stretched by a fixed number of crystal-clock cycles after the last request goes away.

The block keeps a cause register. Software reads it over a simple bus read port, and each read clears it. The block also presents the address of the reset vector, which moves when monitor mode is selected. It drives a clear strobe for the system cycle counter. That strobe is raised only for resets that come from inside the chip, so a pin-only reset leaves the counter running.

The pin is brought into the crystal-clock domain by a synchronizer before anything acts on it. A pin pulse is recorded as the cause only when the pin stayed low long enough and neither a power-on nor a low-voltage reset was involved.

Top module: `rstctl_top`

## Requirements
- R1: Each source forces `sys_rst` high. A watchdog, low-voltage, illegal-opcode or illegal-address request does so at the next clock edge. A low pin does so on the third edge at which it is sampled low, after the two-flop synchronizer.
- R2: With `mon_mode` low, `vec_addr` is 16'hFFFE.
- R3: With `mon_mode` high, `vec_addr` is 16'hFEFE.
- R4: `cnt_clr` is high during a reset in which any internal source (power-on, watchdog, low-voltage, illegal opcode, illegal address) has been requested. It stays low throughout a reset caused by the pin alone.
- R5: Cause bits in `rd_data` are: bit 7 power-on, bit 6 pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 low-voltage, bits 1:0 always zero. Requests that arrive in the same cycle set all of their bits.
- R6: A power-on request leaves `rd_data` at 8'h80. When any other reset begins, the bits left over from earlier resets are cleared and only the new causes remain.
- R7: The pin bit is set only once the synchronized pin has been low for 67 clock cycles. A shorter low pulse still resets the chip but leaves the pin bit clear.
- R8: The pin bit is not set in a reset episode in which power-on or low-voltage was requested before the pin qualified.
- R9: `sys_rst` stays high for as long as the pin is held low.
- R10: A clock edge with `rd_en` high clears the cause register, unless that same edge sets a new cause.
- R11: After the last request is removed, `sys_rst` is released on the 32nd following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| por_req | input | 1 | Power-on request, active high, asynchronous; also resets the block |
| ext_rst_n | input | 1 | Reset pin, active low, asynchronous |
| wdog_req | input | 1 | Watchdog timeout request |
| lvi_req | input | 1 | Low-voltage request |
| ilop_req | input | 1 | Illegal opcode request |
| ilad_req | input | 1 | Illegal address request |
| mon_mode | input | 1 | Monitor mode select |
| rd_en | input | 1 | Cause register read strobe |
| rd_data | output | 8 | Cause register contents |
| sys_rst | output | 1 | Internal reset, active high |
| cnt_clr | output | 1 | System counter clear |
| vec_addr | output | 16 | Reset vector address |

## Verification
The hardest case to reach is a pin reset that overlaps a low-voltage request. The pin has to open the episode, and the low-voltage request must land while the synchronized pin count is still under its threshold. The bench holds the pin low, pulses the low-voltage request a few cycles later, and keeps the pin low well past 67 cycles. It then checks that only the low-voltage bit survives and that the counter clear was raised. Two further pin pulses, at 64 and 70 cycles, sit on either side of the qualification threshold.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
   localparam int ST_W = 8;

   // Cause record; packed order matches the read layout bits 7..2
   typedef struct packed {
      logic por;
      logic pin;
      logic cop;
      logic ilop;
      logic ilad;
      logic lvi;
   } cause_t;

   localparam int CAUSE_W = $bits(cause_t);

   function automatic logic [ST_W-1:0] to_status(input cause_t c);
      return {c, {(ST_W-CAUSE_W){1'b0}}};
   endfunction
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rstctl_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '0;
      else      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstctl_pin_qual.sv
module rstctl_pin_qual #(
   parameter int PIN_MIN = 67
) (
   input  logic clk,
   input  logic arst,
   input  logic low_s,
   output logic qualified
);
   localparam int CW = $clog2(PIN_MIN + 1);
   localparam logic [CW-1:0] LIMIT = CW'(PIN_MIN);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)                low_cnt <= '0;
      else if (!low_s)         low_cnt <= '0;
      else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
   end

   assign qualified = low_s && (low_cnt == LIMIT);
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
   parameter int HOLD = 32
) (
   input  logic clk,
   input  logic arst,
   input  logic any_req,
   input  logic int_req,
   input  logic lvi_req,
   output logic sys_rst,
   output logic int_cause,
   output logic por_lvi,
   output logic start
);
   localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   logic [CW-1:0] hold_cnt;

   assign start = any_req && !sys_rst;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         sys_rst   <= 1'b1;
         hold_cnt  <= '0;
         int_cause <= 1'b1;
         por_lvi   <= 1'b1;
      end else if (any_req) begin
         sys_rst  <= 1'b1;
         hold_cnt <= '0;
         if (start) begin
            int_cause <= int_req;
            por_lvi   <= lvi_req;
         end else begin
            int_cause <= int_cause | int_req;
            por_lvi   <= por_lvi | lvi_req;
         end
      end else if (sys_rst) begin
         if (hold_cnt == LAST) begin
            sys_rst   <= 1'b0;
            hold_cnt  <= '0;
            int_cause <= 1'b0;
            por_lvi   <= 1'b0;
         end else begin
            hold_cnt <= hold_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rstctl_status.sv
module rstctl_status
   import rstctl_pkg::*;
(
   input  logic            clk,
   input  logic            arst,
   input  logic            start,
   input  logic            rd_en,
   input  cause_t          set,
   output logic [ST_W-1:0] status
);
   cause_t por_only;
   logic [ST_W-1:0] nxt;

   always_comb begin
      por_only     = '0;
      por_only.por = 1'b1;
      nxt = status;
      if (rd_en) nxt = '0;
      if (start) nxt = '0;
      nxt = nxt | to_status(set);
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) status <= to_status(por_only);
      else      status <= nxt;
   end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
   import rstctl_pkg::*;
#(
   parameter int          PIN_MIN     = 67,
   parameter int          HOLD        = 32,
   parameter int          SYNC_STAGES = 2,
   parameter int          VEC_W       = 16,
   parameter logic [15:0] VEC_USER    = 16'hFFFE,
   parameter logic [15:0] VEC_MON     = 16'hFEFE
) (
   input  logic             clk,
   input  logic             por_req,
   input  logic             ext_rst_n,
   input  logic             wdog_req,
   input  logic             lvi_req,
   input  logic             ilop_req,
   input  logic             ilad_req,
   input  logic             mon_mode,
   input  logic             rd_en,
   output logic [ST_W-1:0]  rd_data,
   output logic             sys_rst,
   output logic             cnt_clr,
   output logic [VEC_W-1:0] vec_addr
);
   generate
      if (PIN_MIN < 1) begin : g_bad_pin
         $error("rstctl_top: PIN_MIN must be positive");
      end
      if (HOLD < 2) begin : g_bad_hold
         $error("rstctl_top: HOLD must be at least 2");
      end
      if (VEC_W != 16) begin : g_bad_vec
         $error("rstctl_top: VEC_W must be 16");
      end
   endgenerate

   logic   pin_low_s, pin_ok;
   logic   any_req, int_req;
   logic   int_cause, por_lvi, start;
   cause_t set;

   rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst(por_req), .d(~ext_rst_n), .q(pin_low_s)
   );

   rstctl_pin_qual #(.PIN_MIN(PIN_MIN)) u_qual (
      .clk(clk), .arst(por_req), .low_s(pin_low_s), .qualified(pin_ok)
   );

   assign int_req = wdog_req | lvi_req | ilop_req | ilad_req;
   assign any_req = int_req | pin_low_s;

   rstctl_stretch #(.HOLD(HOLD)) u_stretch (
      .clk(clk), .arst(por_req), .any_req(any_req), .int_req(int_req),
      .lvi_req(lvi_req), .sys_rst(sys_rst), .int_cause(int_cause),
      .por_lvi(por_lvi), .start(start)
   );

   always_comb begin
      set      = '0;
      set.pin  = pin_ok && !por_lvi && !lvi_req;
      set.cop  = wdog_req;
      set.ilop = ilop_req;
      set.ilad = ilad_req;
      set.lvi  = lvi_req;
   end

   rstctl_status u_status (
      .clk(clk), .arst(por_req), .start(start), .rd_en(rd_en),
      .set(set), .status(rd_data)
   );

   assign cnt_clr  = sys_rst && int_cause;
   assign vec_addr = mon_mode ? VEC_MON : VEC_USER;
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk (
   input logic       clk,
   input logic       por_req,
   input logic       ext_rst_n,
   input logic       wdog_req,
   input logic       lvi_req,
   input logic       ilop_req,
   input logic       ilad_req,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       sys_rst,
   input logic       cnt_clr
);
   logic int_any;
   assign int_any = wdog_req | lvi_req | ilop_req | ilad_req;

   a_r1_int_req_resets: assert property (@(posedge clk) disable iff (por_req)
      int_any |=> sys_rst);

   a_r4_int_req_clears_cnt: assert property (@(posedge clk) disable iff (por_req)
      int_any |=> cnt_clr);

   a_r4_clr_only_in_reset: assert property (@(posedge clk) disable iff (por_req)
      cnt_clr |-> sys_rst);

   a_r9_pin_low_holds: assert property (@(posedge clk) disable iff (por_req)
      (!ext_rst_n && $past(!ext_rst_n) && $past(!ext_rst_n, 2)) |=> sys_rst);

   a_r10_read_clears: assert property (@(posedge clk) disable iff (por_req)
      (rd_en && !sys_rst && !int_any) |=> (rd_data == 8'h00));

   a_r11_release_quiet: assert property (@(posedge clk) disable iff (por_req)
      $fell(sys_rst) |-> $past(!int_any));
endmodule

bind rstctl_top rstctl_chk u_chk (
   .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
   .lvi_req(lvi_req), .ilop_req(ilop_req), .ilad_req(ilad_req), .rd_en(rd_en),
   .rd_data(rd_data), .sys_rst(sys_rst), .cnt_clr(cnt_clr)
);

// File: tb/rstctl_top_bench.sv
module rstctl_top_bench;
   logic        clk = 1'b0;
   logic        por_req = 1'b1;
   logic        ext_rst_n = 1'b1;
   logic        wdog_req = 1'b0, lvi_req = 1'b0, ilop_req = 1'b0, ilad_req = 1'b0;
   logic        mon_mode = 1'b0, rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic        sys_rst, cnt_clr;
   logic [15:0] vec_addr;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   rstctl_top u_rstctl_top (
      .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
      .lvi_req(lvi_req), .ilop_req(ilop_req), .ilad_req(ilad_req),
      .mon_mode(mon_mode), .rd_en(rd_en), .rd_data(rd_data),
      .sys_rst(sys_rst), .cnt_clr(cnt_clr), .vec_addr(vec_addr)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse_read();
      rd_en = 1'b1; tick(1); rd_en = 1'b0;
   endtask

   task automatic t_power_on();
      tick(3);
      check("R6 por status", 16'(rd_data), 16'h0080);
      check("R4 por cnt_clr", 16'(cnt_clr), 16'h1);
      por_req = 1'b0;
      tick(31);
      check("R11 por hold 31", 16'(sys_rst), 16'h1);
      tick(1);
      check("R11 por release 32", 16'(sys_rst), 16'h0);
      check("R4 clr low after", 16'(cnt_clr), 16'h0);
      check("R2 user vector", vec_addr, 16'hFFFE);
   endtask

   task automatic t_read_clear();
      pulse_read();
      check("R10 read clears", 16'(rd_data), 16'h0000);
   endtask

   task automatic t_watchdog();
      wdog_req = 1'b1; tick(1); wdog_req = 1'b0;
      check("R1 wdog resets", 16'(sys_rst), 16'h1);
      check("R4 wdog cnt_clr", 16'(cnt_clr), 16'h1);
      check("R5 wdog bit", 16'(rd_data), 16'h0020);
      tick(31);
      check("R11 wdog hold", 16'(sys_rst), 16'h1);
      tick(1);
      check("R11 wdog release", 16'(sys_rst), 16'h0);
   endtask

   task automatic t_stale();
      ilop_req = 1'b1; tick(1); ilop_req = 1'b0;
      check("R5 ilop bit", 16'(rd_data), 16'h0010);
      tick(40);
      ilad_req = 1'b1; tick(1); ilad_req = 1'b0;
      check("R6 stale cleared", 16'(rd_data), 16'h0008);
      tick(40);
      lvi_req = 1'b1; tick(1); lvi_req = 1'b0;
      check("R5 lvi bit", 16'(rd_data), 16'h0004);
      tick(40);
      wdog_req = 1'b1; ilad_req = 1'b1; tick(1);
      wdog_req = 1'b0; ilad_req = 1'b0;
      check("R5 two causes", 16'(rd_data), 16'h0028);
      tick(40);
   endtask

   task automatic t_pin_long();
      ext_rst_n = 1'b0;
      tick(3);
      check("R1 pin resets", 16'(sys_rst), 16'h1);
      tick(67);
      check("R9 held while low", 16'(sys_rst), 16'h1);
      check("R4 pin no clr", 16'(cnt_clr), 16'h0);
      ext_rst_n = 1'b1;
      tick(40);
      check("R9 released", 16'(sys_rst), 16'h0);
      check("R7 pin bit set", 16'(rd_data), 16'h0040);
   endtask

   task automatic t_pin_short();
      pulse_read();
      ext_rst_n = 1'b0; tick(64); ext_rst_n = 1'b1;
      tick(40);
      check("R7 short pulse", 16'(rd_data), 16'h0000);
      ext_rst_n = 1'b0; tick(70); ext_rst_n = 1'b1;
      tick(40);
      check("R7 just over", 16'(rd_data), 16'h0040);
   endtask

   task automatic t_pin_lvi();
      ext_rst_n = 1'b0;
      tick(5);
      lvi_req = 1'b1; tick(1); lvi_req = 1'b0;
      tick(95);
      check("R4 lvi in pin episode", 16'(cnt_clr), 16'h1);
      ext_rst_n = 1'b1;
      tick(40);
      check("R8 pin suppressed", 16'(rd_data), 16'h0004);
   endtask

   task automatic t_monitor();
      mon_mode = 1'b1; tick(1);
      check("R3 monitor vector", vec_addr, 16'hFEFE);
      mon_mode = 1'b0; tick(1);
      check("R2 user vector again", vec_addr, 16'hFFFE);
   endtask

   task automatic t_por_again();
      wdog_req = 1'b1; tick(1); wdog_req = 1'b0;
      tick(40);
      por_req = 1'b1; tick(2);
      check("R6 por drops stale", 16'(rd_data), 16'h0080);
      check("R1 por resets", 16'(sys_rst), 16'h1);
      por_req = 1'b0;
      tick(40);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      t_power_on();
      t_read_clear();
      t_watchdog();
      t_stale();
      t_pin_long();
      t_pin_short();
      t_pin_lvi();
      t_monitor();
      t_por_again();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule